// File: doc/BRIEF.md
# Four-input serial ADC scan sequencer

This block is the master side of a link to a four-input, 12-bit serial converter. It runs conversion frames one after another. In each frame it pulls chip select low, toggles a divided serial clock, shifts an 8-bit control word out on the data-to-converter line, and collects the 16-bit reply on the data-from-converter line. The control word carries the address of the input to be sampled. The converter applies that address one frame late: the frame after the one that carried it.

A per-input enable mask chooses which inputs are scanned, in ascending round-robin order. The address carried by a frame is the one the converter uses on the following frame. The block therefore keeps a tag that is one frame behind and labels each 12-bit code with the input it really came from. The first frame after reset always returns input 0, because the converter defaults to that input. Results leave on a valid/ready handshake. The block launches no frame while a result is still waiting, so it needs no output buffer.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is high and just after it, `cs_n` and `sclk` are 1, `din` is 0 and `res_valid` is 0. Reset points both the tag and the round-robin pointer at input 0.
- R2: During each frame the 8-bit control word goes out on `din`, MSB first, one bit per rising `sclk` edge for the first 8 rising edges. Bits 5:3 of the word hold the address {1'b0, input index}. Bits 7:6 and 2:0 are 0, and `din` stays 0 for the rest of the frame.
- R3: A frame holds exactly 16 rising `sclk` edges while `cs_n` is low. `sclk` is 1 whenever `cs_n` is 1, and `din` changes only together with a falling `sclk` edge.
- R4: `dout` is sampled on each rising `sclk` edge. The first 4 sampled bits are dropped, and the last 12, MSB first, become `res_code`.
- R5: Every `sclk` half period, and the time from the fall of `cs_n` to the first fall of `sclk`, lasts max(`sclk_half`,1) clock cycles.
- R6: Between two frames `cs_n` stays high for at least GAP_HALVES `sclk` half periods.
- R7: The address sent in a frame is the first enabled input after the one sent in the previous frame, searching upward and wrapping. After reset the search starts at input 1.
- R8: Each result is labelled on `res_chan` with the input addressed by the frame before it. The first result after reset is labelled 0 and carries the converter's input-0 reply, whatever the mask is.
- R9: `res_valid` stays high with `res_code` and `res_chan` unchanged until a clock edge at which `res_ready` is also high. That edge transfers the result and clears `res_valid`.
- R10: No frame starts while `res_valid` is high.
- R11: With an all-zero mask no frame starts and `cs_n` stays high. A frame already under way finishes and delivers its result.
- R12: The mask is read when a frame starts. A change alters the address of the next frame started, and the labels of results one frame after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_mask | input | 4 | Per-input scan enable, bit i enables input i |
| sclk_half | input | DIV_W | Serial clock half period in clock cycles (0 acts as 1) |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| din | output | 1 | Control bits to the converter |
| dout | input | 1 | Reply bits from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_code | output | 12 | Straight binary conversion code |
| res_chan | output | 2 | Input index the code belongs to |

## Verification
The bench builds the block with DIV_W=4 and GAP_HALVES=3. The narrow divider port lets the run program half periods of 0, 1 and 3 cycles, which covers the clamp of 0 to 1, the fastest link and a slower one with uneven phase. The gap of three half periods is not a whole number of serial clock periods, so a gap counter that is off by one shows up as a short high time on chip select. A behavioural converter model in the bench applies each address one frame late, starts from input 0 after reset, and returns a code that names the input it sampled. This makes a wrong label visible on every result.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int CODE_W     = 12;
    localparam int LEAD_W     = 4;
    localparam int FRAME_BITS = CODE_W + LEAD_W;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);
    localparam int CTRL_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int ADDR_LSB   = 3;
    localparam int NUM_CH     = 4;
    localparam int CH_W       = $clog2(NUM_CH);

    typedef logic [CH_W-1:0]   chan_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef struct packed {
        code_t code;
        chan_t chan;
    } result_t;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_SETUP,
        FS_LOW,
        FS_HIGH
    } fstate_t;

    // control word: address field only, all other bits zero
    function automatic ctrl_t make_ctrl(chan_t ch);
        ctrl_t w;
        w = '0;
        w[ADDR_LSB +: ADDR_W] = ADDR_W'(ch);
        return w;
    endfunction

    function automatic chan_t wrap_add(chan_t base, int unsigned off);
        return chan_t'((int'(base) + off) % NUM_CH);
    endfunction

endpackage

// File: rtl/adc_sclk_tick.sv
module adc_sclk_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_in,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = (half_in == '0) ? DIV_W'(1) : half_in;
        tick = (cnt >= lim - DIV_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/adc_chan_rr.sv
module adc_chan_rr
    import adc_scan_pkg::*;
(
    input  logic [NUM_CH-1:0] mask,
    input  chan_t             last,
    output chan_t             pick,
    output logic              any
);
    chan_t             cand [NUM_CH];
    logic [NUM_CH-1:0] hit;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_cand
        assign cand[k] = wrap_add(last, k + 1);
        assign hit[k]  = mask[cand[k]];
    end

    always_comb begin
        pick = last;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (hit[k]) pick = cand[k];
        end
        any = |mask;
    end
endmodule

// File: rtl/adc_frame_eng.sv
module adc_frame_eng
    import adc_scan_pkg::*;
#(
    parameter int GAP_HALVES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  start,
    input  ctrl_t ctrl_in,
    input  logic  dout,
    output logic  cs_n,
    output logic  sclk,
    output logic  din,
    output logic  launch,
    output logic  done,
    output code_t code
);
    localparam int GAP_W = $clog2(GAP_HALVES + 1);

    fstate_t              st;
    logic [BIT_IDX_W-1:0] bit_idx;
    ctrl_t                ctrl_sh;
    code_t                cap;
    logic [GAP_W-1:0]     gap_cnt;
    logic                 last_bit;

    always_comb begin
        last_bit = (bit_idx == BIT_IDX_W'(FRAME_BITS - 1));
        launch   = tick && (st == FS_IDLE) && (gap_cnt == '0) && start;
        done     = tick && (st == FS_HIGH) && last_bit;
        code     = cap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FS_IDLE;
            cs_n    <= 1'b1;
            sclk    <= 1'b1;
            din     <= 1'b0;
            bit_idx <= '0;
            ctrl_sh <= '0;
            cap     <= '0;
            gap_cnt <= '0;
        end else if (tick) begin
            case (st)
                FS_IDLE: begin
                    if (gap_cnt != '0) begin
                        gap_cnt <= gap_cnt - GAP_W'(1);
                    end else if (start) begin
                        cs_n    <= 1'b0;
                        ctrl_sh <= ctrl_in;
                        st      <= FS_SETUP;
                    end
                end
                FS_SETUP: begin
                    sclk    <= 1'b0;
                    din     <= ctrl_sh[CTRL_W-1];
                    ctrl_sh <= ctrl_sh << 1;
                    bit_idx <= '0;
                    st      <= FS_LOW;
                end
                FS_LOW: begin
                    sclk <= 1'b1;
                    cap  <= {cap[CODE_W-2:0], dout};
                    st   <= FS_HIGH;
                end
                FS_HIGH: begin
                    if (last_bit) begin
                        cs_n    <= 1'b1;
                        din     <= 1'b0;
                        gap_cnt <= GAP_W'(GAP_HALVES - 1);
                        st      <= FS_IDLE;
                    end else begin
                        sclk    <= 1'b0;
                        din     <= ctrl_sh[CTRL_W-1];
                        ctrl_sh <= ctrl_sh << 1;
                        bit_idx <= bit_idx + BIT_IDX_W'(1);
                        st      <= FS_LOW;
                    end
                end
                default: st <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int GAP_HALVES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] en_mask,
    input  logic [DIV_W-1:0]  sclk_half,
    output logic              cs_n,
    output logic              sclk,
    output logic              din,
    input  logic              dout,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [CODE_W-1:0] res_code,
    output logic [CH_W-1:0]   res_chan
);
    logic    tick, launch, done, any_en, start;
    chan_t   last_ch, tag_ch, pick;
    code_t   eng_code;
    result_t out_q;
    logic    valid_q;

    adc_sclk_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .half_in (sclk_half),
        .tick    (tick)
    );

    adc_chan_rr u_rr (
        .mask (en_mask),
        .last (last_ch),
        .pick (pick),
        .any  (any_en)
    );

    assign start = any_en && !valid_q;

    adc_frame_eng #(.GAP_HALVES(GAP_HALVES)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (start),
        .ctrl_in (make_ctrl(pick)),
        .dout    (dout),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .din     (din),
        .launch  (launch),
        .done    (done),
        .code    (eng_code)
    );

    // tag lags the sent address by one frame
    always_ff @(posedge clk) begin
        if (rst) begin
            last_ch <= '0;
            tag_ch  <= '0;
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (launch) last_ch <= pick;
            if (done) begin
                out_q.code <= eng_code;
                out_q.chan <= tag_ch;
                valid_q    <= 1'b1;
                tag_ch     <= last_ch;
            end else if (valid_q && res_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign res_valid = valid_q;
    assign res_code  = out_q.code;
    assign res_chan  = out_q.chan;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
    import adc_scan_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              sclk,
    input logic              din,
    input logic [NUM_CH-1:0] en_mask,
    input logic              res_valid,
    input logic              res_ready,
    input logic [CODE_W-1:0] res_code,
    input logic [CH_W-1:0]   res_chan
);
    logic       sclk_d;
    logic [5:0] rises;
    logic       rise_seen;

    assign rise_seen = sclk && !sclk_d && !cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b1;
            rises  <= '0;
        end else begin
            sclk_d <= sclk;
            if (cs_n)           rises <= '0;
            else if (rise_seen) rises <= rises + 6'd1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (cs_n && sclk && !din && !res_valid));

    // only address bits (indices 2..4 of the sent order) may be 1
    p_dc_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rise_seen && (rises < 6'd2 || rises > 6'd4)) |-> !din);

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    p_frame_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (rises == 6'd16));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=>
            (res_valid && $stable(res_code) && $stable(res_chan)));

    p_no_launch_r10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && cs_n) |=> cs_n);

    p_empty_mask_r11: assert property (@(posedge clk) disable iff (rst)
        (cs_n && en_mask == '0) |=> cs_n);
endmodule

bind adc_scan_ctrl adc_scan_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .din       (din),
    .en_mask   (en_mask),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_code  (res_code),
    .res_chan  (res_chan)
);

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;
    localparam int CLK_PER = 10;
    localparam int DIV_W   = 4;
    localparam int GAP_H   = 3;
    localparam int WD      = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] en_mask = 4'b0000;
    logic [DIV_W-1:0] sclk_half = 4'd1;
    logic       cs_n, sclk, din;
    logic       dout = 1'b0;
    logic       res_valid;
    logic       res_ready = 1'b0;
    logic [11:0] res_code;
    logic [1:0]  res_chan;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    adc_scan_ctrl #(.DIV_W(DIV_W), .GAP_HALVES(GAP_H)) u0 (
        .clk(clk), .rst(rst), .en_mask(en_mask), .sclk_half(sclk_half),
        .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_code(res_code), .res_chan(res_chan)
    );

    initial forever #(CLK_PER/2) clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    // converter model: address applies one frame late, input 0 after reset
    int         wr = 0;
    logic [2:0] m_pend = 3'd0;
    logic [1:0] m_ch;
    logic       m_act = 1'b0, m_have = 1'b0;
    logic [15:0] m_word;
    logic [7:0]  m_ctrl;
    int m_rise, m_fc = 0, m_rise_cyc = 0, m_last_edge, m_hmin, m_hmax, m_gap, iv;
    logic p_cs = 1'bx, p_sk = 1'bx;
    logic [1:0]  rec_ch   [64];
    logic [11:0] rec_code [64];
    logic [7:0]  rec_ctrl [64];
    int rec_rise [64], rec_gap [64], rec_hmin [64], rec_hmax [64];

    always @(cs_n, sclk, rst) begin
        if (rst) begin
            m_pend = 3'd0; m_act = 1'b0; m_have = 1'b0;
        end
        if (cs_n !== p_cs) begin
            if (cs_n === 1'b0 && !rst) begin
                m_act = 1'b1;
                m_ch = m_pend[1:0];
                m_word = {4'b0000, m_ch, m_fc[9:0]};
                dout = m_word[15];
                m_rise = 0; m_ctrl = 8'h00;
                m_gap = m_have ? (cyc - m_rise_cyc) : 9999;
                m_last_edge = cyc; m_hmin = 9999; m_hmax = 0;
            end else if (cs_n === 1'b1 && m_act && !rst) begin
                rec_ch[wr % 64] = m_ch;
                rec_code[wr % 64] = m_word[11:0];
                rec_ctrl[wr % 64] = m_ctrl;
                rec_rise[wr % 64] = m_rise;
                rec_gap[wr % 64] = m_gap;
                rec_hmin[wr % 64] = m_hmin;
                rec_hmax[wr % 64] = m_hmax;
                m_pend = m_ctrl[5:3];
                m_fc = m_fc + 1;
                m_act = 1'b0; m_have = 1'b1; m_rise_cyc = cyc;
                wr = wr + 1;
            end else begin
                m_act = 1'b0;
            end
            p_cs = cs_n;
        end
        if (sclk !== p_sk) begin
            if (m_act) begin
                iv = cyc - m_last_edge;
                if (iv < m_hmin) m_hmin = iv;
                if (iv > m_hmax) m_hmax = iv;
                m_last_edge = cyc;
                if (sclk === 1'b1) begin
                    m_rise = m_rise + 1;
                    if (m_rise <= 8) m_ctrl = {m_ctrl[6:0], din};
                end else if (m_rise >= 1 && m_rise < 16) begin
                    dout = m_word[15 - m_rise];
                end
            end
            p_sk = sclk;
        end
    end

    int rd = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int half, input logic [3:0] m);
        @(negedge clk);
        rst = 1'b1; res_ready = 1'b0; en_mask = m; sclk_half = DIV_W'(half);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        rd = wr;
    endtask

    task automatic wait_valid();
        int n = 0;
        @(negedge clk);
        while (!res_valid && n < 4000) begin
            @(negedge clk); n++;
        end
        chk(res_valid, "R9 result arrives", int'(res_valid), 1);
    endtask

    // take the pending result and check it against the model and expectations
    task automatic take(input int exp_ch, input int exp_addr, input int half);
        int i, he;
        logic [11:0] c; logic [1:0] ch;
        if (!res_valid) wait_valid();
        he = (half == 0) ? 1 : half;
        c = res_code; ch = res_chan; i = rd % 64;
        chk(wr > rd, "R10 frame recorded", wr - rd, 1);
        chk(ch == 2'(exp_ch), "R8 R7 result label", ch, exp_ch);
        chk(ch == rec_ch[i], "R8 label matches sampled input", ch, rec_ch[i]);
        chk(c == rec_code[i], "R4 code", c, rec_code[i]);
        chk(rec_ctrl[i][7:6] == 2'b00 && rec_ctrl[i][2:0] == 3'b000,
            "R2 spare control bits", rec_ctrl[i], {2'b00, 3'(exp_addr), 3'b000});
        chk(rec_ctrl[i][5:3] == 3'(exp_addr), "R7 R2 address sent", rec_ctrl[i][5:3], exp_addr);
        chk(rec_rise[i] == 16, "R3 rising edges", rec_rise[i], 16);
        chk(rec_hmin[i] == he && rec_hmax[i] == he, "R5 half period", rec_hmax[i], he);
        if (rec_gap[i] != 9999)
            chk(rec_gap[i] >= GAP_H * he, "R6 gap", rec_gap[i], GAP_H * he);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(!res_valid, "R9 transfer clears valid", int'(res_valid), 0);
        rd++;
    endtask

    task automatic t_reset();
        do_reset(1, 4'b0000);
        rst = 1'b1;
        @(negedge clk);
        chk(cs_n && sclk && !din && !res_valid, "R1 during reset", {cs_n, sclk, din, res_valid}, 4'b1100);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n && sclk && !din && !res_valid, "R1 after reset", {cs_n, sclk, din, res_valid}, 4'b1100);
    endtask

    task automatic t_full();
        int exp_r [6] = '{0, 1, 2, 3, 0, 1};
        int exp_a [6] = '{1, 2, 3, 0, 1, 2};
        do_reset(1, 4'b1111);
        for (int k = 0; k < 6; k++) take(exp_r[k], exp_a[k], 1);
    endtask

    task automatic t_sparse();
        int exp_r [5] = '{0, 1, 3, 1, 3};
        int exp_a [5] = '{1, 3, 1, 3, 1};
        do_reset(1, 4'b1010);
        for (int k = 0; k < 5; k++) take(exp_r[k], exp_a[k], 1);
    endtask

    task automatic t_divider();
        int exp_r [4] = '{0, 2, 3, 2};
        int exp_a [4] = '{2, 3, 2, 3};
        do_reset(3, 4'b1100);
        for (int k = 0; k < 4; k++) take(exp_r[k], exp_a[k], 3);
    endtask

    task automatic t_stall();
        logic [11:0] c0; logic [1:0] h0; int slips = 0;
        do_reset(1, 4'b1111);
        wait_valid();
        c0 = res_code; h0 = res_chan;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (!res_valid || res_code != c0 || res_chan != h0 || !cs_n) slips++;
        end
        chk(slips == 0, "R9 R10 held while stalled", slips, 0);
        chk(wr - rd == 1, "R10 no frame while result waits", wr - rd, 1);
        take(0, 1, 1);
        take(1, 2, 1);
    endtask

    task automatic t_empty();
        int lows = 0; int w0;
        do_reset(0, 4'b0000);
        w0 = wr;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (!cs_n || !sclk) lows++;
        end
        chk(lows == 0 && wr == w0, "R11 empty mask idle", lows, 0);
        en_mask = 4'b0001;
        take(0, 0, 0);
        while (cs_n) @(negedge clk);
        en_mask = 4'b0000;
        take(0, 0, 0);
        lows = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!cs_n) lows++;
        end
        chk(lows == 0 && wr == rd, "R11 stop after running frame", lows, 0);
    endtask

    task automatic t_maskchg();
        do_reset(1, 4'b0001);
        take(0, 0, 1);
        wait_valid();
        en_mask = 4'b0100;
        take(0, 0, 1);
        take(0, 2, 1);
        take(2, 2, 1);
        chk(1'b1, "R12 sequence done", 0, 0);
    endtask

    initial begin
        bit to = 1'b0;
        fork
            begin
                t_reset();
                t_full();
                t_sparse();
                t_divider();
                t_stall();
                t_empty();
                t_maskchg();
            end
            begin
                repeat (WD) @(negedge clk);
                to = 1'b1;
            end
        join_any
        disable fork;
        if (to) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", WD, 0);
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule